// File: doc/BRIEF.md
# Floating-Point Exception Status and Error Signaling Unit

This block holds the exception state of a coprocessor-style floating-point unit. The arithmetic datapath reports, once per operation, which of six exception conditions it raised. The unit gathers these reports into a sticky flag word that records every event since the flags were last cleared. It also keeps the mask field of the control word, and a per-exception mode vector that chooses when an error is signaled: at once, or only at the next WAIT or floating-point instruction.

The unit signals only unmasked exceptions. It drives a summary error bit and an active-low error line toward an external interrupt controller, and an ignore-error input can hold that line inactive. Decoded instruction strobes act on the state. A clear-exceptions strobe wipes the flags, initialize and state-save strobes reinitialize the unit, and a restore/load-environment strobe overwrites the flags with supplied values.

Top module: `fpx_status`

## Requirements
- R1: The flag word is sticky. Every reported exception bit is ORed into `flags`, and a set flag stays set until a clear, initialize, save or restore strobe acts. Bit positions are 0 invalid, 1 denormal, 2 divide-by-zero, 3 overflow, 4 underflow and 5 precision. `mask_q`, `defer_mode` and `rstr_flags` use the same positions.
- R2: A `clr_stb`, `init_stb` or `save_stb` makes `flags` all zero in the next cycle.
- R3: A `rstr_stb` without a clear, init or save in the same cycle loads `flags` with `rstr_flags` in the next cycle. Reported exceptions in that cycle are not merged.
- R4: When exception reports arrive in the same cycle as a clear, init, save or restore strobe, the strobe wins and the reports do not reach `flags`.
- R5: An exception whose `mask_q` bit is 1 sets its flag but never drives `err_n` low.
- R6: An unmasked exception with `defer_mode` bit 0 drives `err_n` low in the cycle after it is reported, provided `ignore_err` is 0.
- R7: An unmasked exception with `defer_mode` bit 1 leaves `err_n` high until a `wait_stb` arrives. `err_n` goes low in the cycle after that strobe.
- R8: A clear, init, save or restore strobe cancels both a pending deferred error and an active error. `err_n` is high in the next cycle.
- R9: While `ignore_err` is 1, `err_n` is 1. An error that is still active drives `err_n` low again once `ignore_err` returns to 0.
- R10: `err_sum` equals the OR over all flags whose `mask_q` bit is 0.
- R11: Synchronous active-high `rst`, `init_stb` and `save_stb` each set `mask_q` to all ones and clear the flags and any pending or active error.
- R12: `mask_wr` loads `mask_in` into `mask_q` in the next cycle. A same-cycle init or save takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_valid | input | 1 | An operation is reporting exceptions this cycle |
| exc_bits | input | NEXC | Exceptions raised by that operation |
| mask_wr | input | 1 | Write the mask field |
| mask_in | input | NEXC | New mask field (1 = masked) |
| defer_mode | input | NEXC | Per exception: 1 = signal at next WAIT/FP instruction |
| clr_stb | input | 1 | Clear-exceptions instruction |
| init_stb | input | 1 | Initialize instruction |
| save_stb | input | 1 | State-save instruction (also reinitializes) |
| rstr_stb | input | 1 | Restore/load-environment instruction |
| rstr_flags | input | NEXC | Flag values supplied by the restore |
| wait_stb | input | 1 | WAIT or next floating-point instruction |
| ignore_err | input | 1 | Suppress the error line |
| flags | output | NEXC | Sticky exception flags |
| mask_q | output | NEXC | Current mask field |
| err_sum | output | 1 | Summary error bit |
| err_n | output | 1 | Active-low error line |

## Verification
The bench builds the unit with the default of six exception kinds. This keeps all 64 flag, mask and mode patterns within reach of random stimulus, so every bit position meets masking, both signaling modes and every kind of strobe. Directed cases cover the collisions: a report meeting a clear or restore, a deferred report meeting a WAIT strobe, and ignore-error rising and falling while an error is active.

// File: rtl/fpx_status.sv
module fpx_status #(
  parameter int NEXC = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            exc_valid,
  input  logic [NEXC-1:0] exc_bits,
  input  logic            mask_wr,
  input  logic [NEXC-1:0] mask_in,
  input  logic [NEXC-1:0] defer_mode,
  input  logic            clr_stb,
  input  logic            init_stb,
  input  logic            save_stb,
  input  logic            rstr_stb,
  input  logic [NEXC-1:0] rstr_flags,
  input  logic            wait_stb,
  input  logic            ignore_err,
  output logic [NEXC-1:0] flags,
  output logic [NEXC-1:0] mask_q,
  output logic            err_sum,
  output logic            err_n
);

  localparam logic [NEXC-1:0] ALL_ONES = {NEXC{1'b1}};

  logic            reinit, wipe, cancel;
  logic [NEXC-1:0] unm_new;
  logic            new_imm, new_def;
  logic            pend_q, act_q;

  assign reinit  = init_stb | save_stb;
  assign wipe    = clr_stb | reinit;
  assign cancel  = wipe | rstr_stb;
  assign unm_new = exc_valid ? (exc_bits & ~mask_q) : '0;
  assign new_imm = |(unm_new & ~defer_mode);
  assign new_def = |(unm_new & defer_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags  <= '0;
      mask_q <= ALL_ONES;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (wipe)           flags <= '0;
      else if (rstr_stb)  flags <= rstr_flags;
      else if (exc_valid) flags <= flags | exc_bits;

      if (reinit)       mask_q <= ALL_ONES;
      else if (mask_wr) mask_q <= mask_in;

      if (cancel) begin
        pend_q <= 1'b0;
        act_q  <= 1'b0;
      end else if (wait_stb) begin
        pend_q <= 1'b0;
        act_q  <= act_q | pend_q | new_def | new_imm;
      end else begin
        pend_q <= pend_q | new_def;
        act_q  <= act_q | new_imm;
      end
    end
  end

  assign err_sum = |(flags & ~mask_q);
  assign err_n   = ~(act_q & err_sum & ~ignore_err);

  p_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    !cancel |=> ((flags & $past(flags)) == $past(flags)));

  p_wipe_r2: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (flags == '0));

  p_restore_r3: assert property (@(posedge clk) disable iff (rst)
    (rstr_stb && !wipe) |=> (flags == $past(rstr_flags)));

  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !err_n |-> ((flags & ~mask_q) != '0));

  p_defer_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!wait_stb && !act_q && !new_imm) |=> !act_q);

  p_cancel_r8: assert property (@(posedge clk) disable iff (rst)
    cancel |=> err_n);

  p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    ignore_err |-> err_n);

  p_reinit_mask_r11: assert property (@(posedge clk) disable iff (rst)
    reinit |=> (mask_q == ALL_ONES));

endmodule

// File: tb/sim_fpx_status.sv
`timescale 1ns/1ps
module sim_fpx_status;
  localparam int N = 6;

  logic clk = 0, rst = 1;
  logic exc_valid = 0, mask_wr = 0, clr_stb = 0, init_stb = 0, save_stb = 0;
  logic rstr_stb = 0, wait_stb = 0, ignore_err = 0;
  logic [N-1:0] exc_bits = '0, mask_in = '0, defer_mode = '0, rstr_flags = '0;
  logic [N-1:0] flags, mask_q;
  logic err_sum, err_n;

  int n_chk = 0, n_fail = 0;
  logic [N-1:0] m_flags, m_mask;
  logic m_pend, m_act;

  always #5 clk = ~clk;

  fpx_status #(.NEXC(N)) u0 (
    .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_bits(exc_bits),
    .mask_wr(mask_wr), .mask_in(mask_in), .defer_mode(defer_mode),
    .clr_stb(clr_stb), .init_stb(init_stb), .save_stb(save_stb),
    .rstr_stb(rstr_stb), .rstr_flags(rstr_flags), .wait_stb(wait_stb),
    .ignore_err(ignore_err), .flags(flags), .mask_q(mask_q),
    .err_sum(err_sum), .err_n(err_n));

  function automatic logic f_sum(logic [N-1:0] f, logic [N-1:0] m);
    return |(f & ~m);
  endfunction

  function automatic logic f_errn(logic a, logic [N-1:0] f, logic [N-1:0] m, logic ign);
    return ~(a & f_sum(f, m) & ~ign);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [N-1:0] un;
    logic wp, cn, ni, nd;
    if (rst) begin
      m_flags = '0; m_mask = '1; m_pend = 0; m_act = 0;
      return;
    end
    wp = clr_stb | init_stb | save_stb;
    cn = wp | rstr_stb;
    un = exc_valid ? (exc_bits & ~m_mask) : '0;
    ni = |(un & ~defer_mode);
    nd = |(un & defer_mode);
    if (cn) begin m_pend = 0; m_act = 0; end
    else if (wait_stb) begin m_act = m_act | m_pend | nd | ni; m_pend = 0; end
    else begin m_pend = m_pend | nd; m_act = m_act | ni; end
    if (wp) m_flags = '0;
    else if (rstr_stb) m_flags = rstr_flags;
    else if (exc_valid) m_flags = m_flags | exc_bits;
    if (init_stb | save_stb) m_mask = '1;
    else if (mask_wr) m_mask = mask_in;
  endtask

  task automatic step();
    @(posedge clk);
    model_step();
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    exc_valid = 0; mask_wr = 0; clr_stb = 0; init_stb = 0; save_stb = 0;
    rstr_stb = 0; wait_stb = 0;
  endtask

  task automatic check_all();
    chk("R1 flags", flags, m_flags);
    chk("R12 mask", mask_q, m_mask);
    chk("R10 err_sum", err_sum, f_sum(m_flags, m_mask));
    chk("R6 err_n", err_n, f_errn(m_act, m_flags, m_mask, ignore_err));
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1; step(); step();
    idle(); rst = 0;
    chk("R11 reset flags", flags, 0);
    chk("R11 reset mask", mask_q, 6'h3f);
    chk("R11 reset err_n", err_n, 1);

    // R5: masked exception sets flag, no error
    idle(); exc_valid = 1; exc_bits = 6'h04; step();
    chk("R5 flag set", flags, 6'h04);
    chk("R5 masked err_n", err_n, 1);
    chk("R10 masked sum", err_sum, 0);

    // R12: unmask all, immediate mode
    idle(); mask_wr = 1; mask_in = 6'h00; defer_mode = 6'h00; step();
    chk("R12 mask write", mask_q, 6'h00);
    chk("R10 sum after unmask", err_sum, 1);
    chk("R6 old flag not active", err_n, 1);

    // R6: immediate unmasked exception
    idle(); exc_valid = 1; exc_bits = 6'h08; step();
    chk("R1 accumulate", flags, 6'h0c);
    chk("R6 immediate err_n", err_n, 0);

    // R9: ignore gating
    idle(); ignore_err = 1; #1;
    chk("R9 ignore high", err_n, 1);
    idle(); ignore_err = 0; #1;
    chk("R9 resume low", err_n, 0);

    // R4/R2: clear beats report
    idle(); clr_stb = 1; exc_valid = 1; exc_bits = 6'h3f; step();
    chk("R4 clear wins", flags, 0);
    chk("R8 clear cancels", err_n, 1);

    // R7: deferred
    idle(); defer_mode = 6'h3f; exc_valid = 1; exc_bits = 6'h01; step();
    chk("R7 deferred flag", flags, 6'h01);
    chk("R7 deferred quiet", err_n, 1);
    idle(); step(); step();
    chk("R7 still quiet", err_n, 1);
    idle(); wait_stb = 1; step();
    chk("R7 after wait", err_n, 0);

    // R3/R4: restore beats report
    idle(); rstr_stb = 1; rstr_flags = 6'h12; exc_valid = 1; exc_bits = 6'h21; step();
    chk("R3 restore value", flags, 6'h12);
    chk("R8 restore cancels", err_n, 1);

    // R8: pending cancelled by clear then wait
    idle(); exc_valid = 1; exc_bits = 6'h02; step();
    idle(); clr_stb = 1; step();
    idle(); wait_stb = 1; step();
    chk("R8 pending cancelled", err_n, 1);

    // R11/R12: init beats mask write
    idle(); init_stb = 1; mask_wr = 1; mask_in = 6'h00; step();
    chk("R11 init mask", mask_q, 6'h3f);
    chk("R12 init priority", flags, 0);
    idle(); save_stb = 1; step();
    chk("R2 save flags", flags, 0);

    // random
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      exc_valid  = ($urandom % 3) == 0;
      exc_bits   = $urandom;
      mask_wr    = ($urandom % 12) == 0;
      mask_in    = $urandom;
      defer_mode = $urandom;
      clr_stb    = ($urandom % 40) == 0;
      init_stb   = ($urandom % 80) == 0;
      save_stb   = ($urandom % 80) == 0;
      rstr_stb   = ($urandom % 40) == 0;
      rstr_flags = $urandom;
      wait_stb   = ($urandom % 6) == 0;
      ignore_err = ($urandom % 10) == 0;
      step();
      check_all();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule